// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Bank

This block sits beside a small 8-bit processor core and watches two streams: the program counter of each instruction the core is about to execute, and every data transaction the core makes into program memory, data memory or the special-function register space. Four independent slots each hold a match address, an address-space select, a condition code and an 8-bit compare value. When an armed slot matches, the unit stops the core. The core runs at full clock speed until a real match occurs. While the core is halted its peripherals keep running.

An execution match stalls the fetch in the same cycle. The matching instruction therefore never starts, and a registered halt level follows on the next clock. A data-access match is noted when the access strobe is valid. The stop then takes effect at the next instruction boundary, which is the next presented fetch. A debug controller programs the slots through a small word-addressed register port. It reads which slots caused the stop, clears those status bits by writing ones, and writes a resume command. That command releases the halt and lets the core step past an execution breakpoint once.

Top module: `hwbrk_unit`

## Requirements
- R1: Four slots, each with a match-address register at `reg_addr` = {2'b00, slot[1:0], 1'b0} and a config register at {2'b00, slot[1:0], 1'b1}. The config register is laid out as bits [7:0] compare data, bits [10:8] condition and bits [13:12] space. Both registers read back what was written, and all other bits read as zero.
- R2: Condition 3'b001 (execute) matches when `fetch_valid` is high and `fetch_pc` equals the slot address, whatever the space field holds. `fetch_stall` rises in that same cycle, so the instruction does not execute, and `halt` is high from the next cycle on.
- R3: Condition 3'b010 (any write) and condition 3'b011 (any read) match an access with `acc_valid` high, with `acc_space` equal to the slot space and with `acc_addr` equal to the slot address. The access direction must also agree: `acc_write` is 1 for a write and 0 for a read. Space codes are 00 program, 01 data and 10 special-function.
- R4: Condition 3'b100 (write with data) and condition 3'b101 (read with data) add one more test to R3: `acc_data` must equal the slot compare value.
- R5: A slot never matches when its condition is 3'b000 or 3'b11x, when a data condition has space code 11, when the space or address differs, or when an execute slot sees only a data access.
- R6: A data match does not raise `halt` at once. At the next cycle with `fetch_valid` high, `fetch_stall` is high in that cycle and `halt` rises on the following cycle.
- R7: `halt` stays high until a resume command arrives, and it is low in the cycle after the command. The command is a write of bit 0 = 1 to `reg_addr` 5'h11.
- R8: After a resume, execute matches are suppressed for the first fetch only. Later fetches at the same address stop the core again.
- R9: The status register at `reg_addr` 5'h10 holds one bit per slot in bits [3:0] and the `halt` level in bit 4. A slot's bit is set when that slot's match is recorded. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R10: While `halt` is high, no slot match is recorded and no further stop is queued.
- R11: After reset, `halt`, `fetch_stall`, all status bits and all slot registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction at `fetch_pc` is about to execute |
| fetch_pc | input | 16 | Program counter of that instruction |
| acc_valid | input | 1 | Data access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | Space of the access (00 program, 01 data, 10 special-function) |
| acc_addr | input | 16 | Access address |
| acc_data | input | 8 | Data written or read |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| halt | output | 1 | Registered halt level |
| fetch_stall | output | 1 | Holds the current fetch; high while halted or on a stopping fetch |

## Verification
The hardest state to reach from the ports is the interplay between a resume and a breakpoint at the same program counter. To reach it, the bench first halts on an execute slot. It then issues the resume command, presents the very same address twice and checks that the first fetch passes and the second one stops. It also clears the status while the core is still halted and then fires a matching data access, which shows that nothing is recorded during a halt. Finally, a data match is left pending across idle cycles before any fetch arrives, to show that the stop waits for the instruction boundary.

// File: rtl/hwbrk_pkg.sv
package hwbrk_pkg;

  localparam int unsigned COND_W  = 3;
  localparam int unsigned SPACE_W = 2;

  typedef enum logic [COND_W-1:0] {
    COND_OFF  = 3'b000,
    COND_EXEC = 3'b001,
    COND_WR   = 3'b010,
    COND_RD   = 3'b011,
    COND_WRD  = 3'b100,
    COND_RDD  = 3'b101
  } cond_e;

  localparam logic [SPACE_W-1:0] SPACE_RSVD = 2'b11;

  // register map (word addresses)
  localparam logic [4:0] REG_STATUS = 5'h10;
  localparam logic [4:0] REG_CTRL   = 5'h11;

  // config register field positions
  localparam int unsigned CFG_COND_LSB  = 8;
  localparam int unsigned CFG_SPACE_LSB = 12;

endpackage

// File: rtl/hwbrk_slot.sv
module hwbrk_slot
  import hwbrk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_we,
  input  logic               cfg_we,
  input  logic [AW-1:0]      addr_wval,
  input  logic [SPACE_W-1:0] space_wval,
  input  logic [COND_W-1:0]  cond_wval,
  input  logic [DW-1:0]      data_wval,
  output logic [AW-1:0]      addr_q,
  output logic [SPACE_W-1:0] space_q,
  output logic [COND_W-1:0]  cond_q,
  output logic [DW-1:0]      data_q,
  input  logic               fetch_valid,
  input  logic [AW-1:0]      fetch_pc,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [SPACE_W-1:0] acc_space,
  input  logic [AW-1:0]      acc_addr,
  input  logic [DW-1:0]      acc_data,
  output logic               exec_hit,
  output logic               data_hit
);

  logic [AW-1:0]      addr_d;
  logic [SPACE_W-1:0] space_d;
  logic [COND_W-1:0]  cond_d;
  logic [DW-1:0]      data_d;
  logic               loc_ok;
  logic               val_ok;

  // next-state for configuration
  always_comb begin
    addr_d  = addr_q;
    space_d = space_q;
    cond_d  = cond_q;
    data_d  = data_q;
    if (addr_we) begin
      addr_d = addr_wval;
    end
    if (cfg_we) begin
      space_d = space_wval;
      cond_d  = cond_wval;
      data_d  = data_wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      space_q <= '0;
      cond_q  <= '0;
      data_q  <= '0;
    end else begin
      addr_q  <= addr_d;
      space_q <= space_d;
      cond_q  <= cond_d;
      data_q  <= data_d;
    end
  end

  // comparators
  always_comb begin
    loc_ok   = acc_valid && (acc_space == space_q) && (space_q != SPACE_RSVD)
               && (acc_addr == addr_q);
    val_ok   = (acc_data == data_q);
    exec_hit = 1'b0;
    data_hit = 1'b0;
    case (cond_q)
      COND_EXEC: exec_hit = fetch_valid && (fetch_pc == addr_q);
      COND_WR:   data_hit = loc_ok && acc_write;
      COND_RD:   data_hit = loc_ok && !acc_write;
      COND_WRD:  data_hit = loc_ok && acc_write && val_ok;
      COND_RDD:  data_hit = loc_ok && !acc_write && val_ok;
      default:   ;
    endcase
  end

  // R5: a disarmed slot stays silent
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q == COND_OFF) |-> (!exec_hit && !data_hit));

  // R3: a data hit needs a live access strobe
  p_hit_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |-> acc_valid);

endmodule

// File: rtl/hwbrk_ctrl.sv
module hwbrk_ctrl #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  input  logic [NUM_SLOTS-1:0] exec_hits,
  input  logic [NUM_SLOTS-1:0] data_hits,
  input  logic                 resume,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  output logic                 halt,
  output logic                 fetch_stall,
  output logic [NUM_SLOTS-1:0] status
);

  logic                 halt_q, halt_d;
  logic                 pend_q, pend_d;
  logic                 skip_q, skip_d;
  logic [NUM_SLOTS-1:0] status_q, status_d;
  logic                 exec_gate;
  logic [NUM_SLOTS-1:0] exec_new, data_new, new_hits;
  logic                 stop_now;

  always_comb begin
    exec_gate = !halt_q && !skip_q;
    exec_new  = exec_hits & {NUM_SLOTS{exec_gate}};
    data_new  = data_hits & {NUM_SLOTS{!halt_q}};
    new_hits  = exec_new | data_new;
    stop_now  = fetch_valid && !halt_q && (pend_q || (|exec_new));

    halt_d = halt_q;
    if (resume)        halt_d = 1'b0;
    else if (stop_now) halt_d = 1'b1;

    pend_d = pend_q;
    if (resume)          pend_d = 1'b0;
    else if (|data_new)  pend_d = 1'b1;
    else if (stop_now)   pend_d = 1'b0;

    skip_d = skip_q;
    if (resume)                        skip_d = 1'b1;
    else if (fetch_valid && !halt_q)   skip_d = 1'b0;

    status_d = (status_q & ~clr_mask) | new_hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b0;
      pend_q   <= 1'b0;
      skip_q   <= 1'b0;
      status_q <= '0;
    end else begin
      halt_q   <= halt_d;
      pend_q   <= pend_d;
      skip_q   <= skip_d;
      status_q <= status_d;
    end
  end

  assign halt        = halt_q;
  assign fetch_stall = halt_q || stop_now;
  assign status      = status_q;

  // R7: halt holds until resume
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !resume) |=> halt_q);

  // R7: resume releases
  p_resume_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !halt_q);

  // R2: an armed execute match halts on the next cycle
  p_exec_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && (|exec_hits) && !halt_q && !skip_q && !resume) |=> halt_q);

  // R6: a pending data match halts at the next fetch
  p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && pend_q && !halt_q && !resume) |=> halt_q);

  // R9: recorded hits appear in status
  p_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_hits) |=> ((status_q & $past(new_hits)) == $past(new_hits)));

  // R8: the fetch right after resume never stops on an execute match
  p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && !pend_q && fetch_valid && !halt_q && !resume) |=> !halt_q);

endmodule

// File: rtl/hwbrk_unit.sv
module hwbrk_unit
  import hwbrk_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned REG_DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              halt,
  output logic              fetch_stall
);

  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                 slot_sel;
  logic [IDX_W-1:0]     slot_idx;
  logic                 status_we, ctrl_we, resume;
  logic [NUM_SLOTS-1:0] clr_mask;
  logic [NUM_SLOTS-1:0] exec_hits, data_hits, status;

  logic [ADDR_W-1:0]  s_addr  [NUM_SLOTS];
  logic [SPACE_W-1:0] s_space [NUM_SLOTS];
  logic [COND_W-1:0]  s_cond  [NUM_SLOTS];
  logic [DATA_W-1:0]  s_data  [NUM_SLOTS];

  always_comb begin
    slot_idx  = reg_addr[IDX_W:1];
    slot_sel  = (reg_addr[REG_AW-1:IDX_W+1] == '0) && (32'(slot_idx) < NUM_SLOTS);
    status_we = reg_we && (reg_addr == REG_STATUS);
    ctrl_we   = reg_we && (reg_addr == REG_CTRL);
    resume    = ctrl_we && reg_wdata[0];
    clr_mask  = status_we ? reg_wdata[NUM_SLOTS-1:0] : '0;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_sel;
    assign hit_sel = reg_we && slot_sel && (32'(slot_idx) == g);

    hwbrk_slot #(.AW(ADDR_W), .DW(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .addr_we    (hit_sel && !reg_addr[0]),
      .cfg_we     (hit_sel && reg_addr[0]),
      .addr_wval  (reg_wdata[ADDR_W-1:0]),
      .space_wval (reg_wdata[CFG_SPACE_LSB +: SPACE_W]),
      .cond_wval  (reg_wdata[CFG_COND_LSB +: COND_W]),
      .data_wval  (reg_wdata[DATA_W-1:0]),
      .addr_q     (s_addr[g]),
      .space_q    (s_space[g]),
      .cond_q     (s_cond[g]),
      .data_q     (s_data[g]),
      .fetch_valid(fetch_valid),
      .fetch_pc   (fetch_pc),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_space  (acc_space),
      .acc_addr   (acc_addr),
      .acc_data   (acc_data),
      .exec_hit   (exec_hits[g]),
      .data_hit   (data_hits[g])
    );
  end

  hwbrk_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .fetch_valid(fetch_valid),
    .exec_hits  (exec_hits),
    .data_hits  (data_hits),
    .resume     (resume),
    .clr_mask   (clr_mask),
    .halt       (halt),
    .fetch_stall(fetch_stall),
    .status     (status)
  );

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_STATUS) begin
      reg_rdata[NUM_SLOTS-1:0] = status;
      reg_rdata[NUM_SLOTS]     = halt;
    end else if (slot_sel) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (32'(slot_idx) == i) begin
          if (reg_addr[0]) begin
            reg_rdata[DATA_W-1:0]                  = s_data[i];
            reg_rdata[CFG_COND_LSB +: COND_W]      = s_cond[i];
            reg_rdata[CFG_SPACE_LSB +: SPACE_W]    = s_space[i];
          end else begin
            reg_rdata[ADDR_W-1:0] = s_addr[i];
          end
        end
      end
    end
  end

  // R10: while halted, the stall is held and status cannot gain bits
  p_halt_stalls_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (halt && !resume) |=> ((status & ~$past(status)) == '0));

endmodule

// File: tb/hwbrk_unit_tb.sv
module hwbrk_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [15:0] fetch_pc;
  logic        acc_valid;
  logic        acc_write;
  logic [1:0]  acc_space;
  logic [15:0] acc_addr;
  logic [7:0]  acc_data;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        halt;
  logic        fetch_stall;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hwbrk_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_space(acc_space),
    .acc_addr(acc_addr), .acc_data(acc_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .halt(halt), .fetch_stall(fetch_stall)
  );

  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;

  typedef struct packed {
    logic [2:0]  cond;
    logic [1:0]  space;
    logic [7:0]  data;
    logic [1:0]  kind;
    logic [1:0]  sspace;
    logic [15:0] saddr;
    logic [7:0]  sdata;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 2'd0, 8'h00, K_FETCH, 2'd0, 16'h1234, 8'h00, 5'h11}, // R2
    '{3'b001, 2'd0, 8'h00, K_FETCH, 2'd0, 16'h1235, 8'h00, 5'h00}, // R5
    '{3'b010, 2'd1, 8'h00, K_WRITE, 2'd1, 16'h1234, 8'h77, 5'h01}, // R3
    '{3'b010, 2'd1, 8'h00, K_READ,  2'd1, 16'h1234, 8'h77, 5'h00}, // R3
    '{3'b011, 2'd2, 8'h00, K_READ,  2'd2, 16'h1234, 8'h10, 5'h01}, // R3
    '{3'b011, 2'd2, 8'h00, K_READ,  2'd1, 16'h1234, 8'h10, 5'h00}, // R5
    '{3'b100, 2'd1, 8'hA5, K_WRITE, 2'd1, 16'h1234, 8'hA5, 5'h01}, // R4
    '{3'b100, 2'd1, 8'hA5, K_WRITE, 2'd1, 16'h1234, 8'hA4, 5'h00}, // R4
    '{3'b101, 2'd0, 8'h3C, K_READ,  2'd0, 16'h1234, 8'h3C, 5'h01}, // R4
    '{3'b101, 2'd0, 8'h3C, K_READ,  2'd0, 16'h1230, 8'h3C, 5'h00}, // R5
    '{3'b010, 2'd3, 8'h00, K_WRITE, 2'd3, 16'h1234, 8'h00, 5'h00}, // R5
    '{3'b110, 2'd1, 8'h00, K_WRITE, 2'd1, 16'h1234, 8'h00, 5'h00}, // R5
    '{3'b000, 2'd0, 8'h00, K_FETCH, 2'd0, 16'h1234, 8'h00, 5'h00}, // R5
    '{3'b001, 2'd0, 8'h00, K_WRITE, 2'd0, 16'h1234, 8'h00, 5'h00}  // R5
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_fetch(input logic [15:0] pc, output logic stall);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    #1;
    stall = fetch_stall;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic do_access(input logic wr, input logic [1:0] sp,
                           input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_space = sp; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic cfg_slot(input int s, input logic [15:0] a, input logic [2:0] c,
                          input logic [1:0] sp, input logic [7:0] d);
    reg_wr(5'(s * 2), a);
    reg_wr(5'(s * 2 + 1), {2'b00, sp, 1'b0, c, d});
  endtask

  task automatic recover();
    logic st;
    reg_wr(5'h10, 16'h000F);
    reg_wr(5'h11, 16'h0001);
    do_fetch(16'hFFF0, st);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        st;
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_pc = '0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_space = '0; acc_addr = '0; acc_data = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    reg_rd(5'h10, rd); chk("R11 status", rd, 16'h0000);
    reg_rd(5'h05, rd); chk("R11 slot2 cfg", rd, 16'h0000);
    chk("R11 halt", {15'd0, halt}, 16'd0);
    chk("R11 stall", {15'd0, fetch_stall}, 16'd0);

    // R1: readback of slot 3
    cfg_slot(3, 16'hBEEF, 3'b000, 2'd2, 8'hA5);
    reg_rd(5'h06, rd); chk("R1 addr readback", rd, 16'hBEEF);
    reg_rd(5'h07, rd); chk("R1 cfg readback", rd, 16'h20A5);
    reg_wr(5'h07, 16'hFFFF);
    reg_rd(5'h07, rd); chk("R1 cfg unused bits zero", rd, 16'h37FF);
    reg_wr(5'h07, 16'h0000);

    // table walk on slot 0 (R2..R5)
    for (int i = 0; i < NV; i++) begin
      cfg_slot(0, 16'h1234, VEC[i].cond, VEC[i].space, VEC[i].data);
      if (VEC[i].kind == K_FETCH) do_fetch(VEC[i].saddr, st);
      else do_access(VEC[i].kind == K_WRITE, VEC[i].sspace, VEC[i].saddr, VEC[i].sdata);
      reg_rd(5'h10, rd);
      chk($sformatf("R2-5 vector %0d status", i), rd, {11'd0, VEC[i].exp});
      reg_wr(5'h01, 16'h0000);
      recover();
    end

    // R6: data match waits for the instruction boundary
    cfg_slot(1, 16'h0040, 3'b010, 2'd1, 8'h00);
    do_access(1'b1, 2'd1, 16'h0040, 8'h12);
    repeat (2) @(negedge clk);
    chk("R6 no halt before fetch", {15'd0, halt}, 16'd0);
    do_fetch(16'h0100, st);
    chk("R6 stall on boundary fetch", {15'd0, st}, 16'd1);
    chk("R6 halt after boundary", {15'd0, halt}, 16'd1);

    // R10: matches ignored while halted
    reg_wr(5'h10, 16'h000F);
    do_access(1'b1, 2'd1, 16'h0040, 8'h12);
    reg_rd(5'h10, rd); chk("R10 no record while halted", rd, 16'h0010);

    // R7: halt holds, resume releases
    repeat (4) @(negedge clk);
    chk("R7 halt held", {15'd0, halt}, 16'd1);
    reg_wr(5'h11, 16'h0001);
    chk("R7 released by resume", {15'd0, halt}, 16'd0);
    reg_wr(5'h03, 16'h0000);
    do_fetch(16'hFFF0, st);
    chk("R7 pending cleared by resume", {15'd0, halt}, 16'd0);

    // R8: step past an execute breakpoint once
    cfg_slot(0, 16'h0200, 3'b001, 2'd0, 8'h00);
    do_fetch(16'h0200, st);
    chk("R2 stall same cycle", {15'd0, st}, 16'd1);
    chk("R2 halt next cycle", {15'd0, halt}, 16'd1);
    reg_wr(5'h11, 16'h0001);
    do_fetch(16'h0200, st);
    chk("R8 first fetch passes", {15'd0, st}, 16'd0);
    chk("R8 no halt after first fetch", {15'd0, halt}, 16'd0);
    do_fetch(16'h0200, st);
    chk("R8 second fetch stops", {15'd0, st}, 16'd1);
    reg_wr(5'h01, 16'h0000);
    recover();

    // R9: two slots hit together, W1C per bit
    cfg_slot(0, 16'h0300, 3'b001, 2'd0, 8'h00);
    cfg_slot(2, 16'h0300, 3'b001, 2'd1, 8'h00);
    do_fetch(16'h0300, st);
    reg_rd(5'h10, rd); chk("R9 both slots recorded", rd, 16'h0015);
    reg_wr(5'h10, 16'h0001);
    reg_rd(5'h10, rd); chk("R9 clear bit 0 only", rd, 16'h0014);
    reg_wr(5'h10, 16'h0000);
    reg_rd(5'h10, rd); chk("R9 zero write no effect", rd, 16'h0014);
    reg_wr(5'h10, 16'h0004);
    reg_rd(5'h10, rd); chk("R9 clear bit 2", rd, 16'h0010);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule